// File: doc/BRIEF.md
# Stereo Audio Serial Transmitter

This block sends a stereo pair of 24-bit two's-complement samples, left and right, over one serial data line. A frame clock marks which channel is on the line, and a bit clock times each bit. The line changes after each falling edge of the bit clock, so a receiver can capture on the rising edge. The most significant bit goes first. Two framings are available through `fmt_i2s`. In the justified framing, data starts in the first slot after a frame clock edge. In the I2S framing, the whole stream is one bit clock later and the frame clock polarity is inverted.

The block can generate the clocks itself as master, with a 64fs bit clock derived from the system clock. It can also run as slave, following an external bit clock and frame clock. In slave mode the bit clock may run at 64fs, 48fs or 32fs, and at 32fs only the upper 16 bits of each sample are sent. All logic runs on the system clock, and the slave clocks are sampled in that clock domain.

Sample pairs enter through a valid/ready port and go into a one-entry holding register. `s_ready` is high while that register is empty. A pair is accepted on any clock edge where `s_valid` and `s_ready` are both high. Once `s_valid` is raised, the source must keep it high and keep the data stable until the pair is accepted. The held pair is moved into the active pair at the first bit slot of each left half-frame, and the holding register is freed in the same cycle. This lets the source refill it while the current frame is still being sent.

Top module: `aud_ser_tx`

## Requirements
- R1: While `rst_n` is low, `sdata`, `bclk_out` and `fclk_out` are 0 and `s_ready` is 1.
- R2: With `master_en` high, `bclk_out` has a period of 2*CLK_HALF system clocks, `fclk_out` toggles only together with a falling edge of `bclk_out`, and each frame clock half lasts HALF_SLOTS (32) bit clocks. `slv_rate` has no effect in master mode.
- R3: `sdata` changes only in the system clock cycle that follows a detected falling edge of the bit clock in use, so it is stable at every rising edge.
- R4: With `fmt_i2s` low, a high frame clock means the left channel. The MSB goes in slot 0, the slot that begins at the falling edge where the frame clock change is seen. Bits follow MSB first, and slots past the last data bit carry 0.
- R5: With `fmt_i2s` high, a low frame clock means the left channel. The serial stream is the R4 stream delayed by one slot: the MSB is in slot 1, and slot 0 carries the last slot of the previous half-frame.
- R6: In slave mode `slv_rate` selects the bit clock rate: 0 means 64fs (32 slots per half), 1 means 48fs (24 slots per half, every slot carrying data), and 2 means 32fs (16 slots per half).
- R7: With `slv_rate` equal to 2 in slave mode, only sample bits 23 down to 8 are sent.
- R8: `s_ready` equals "holding register empty". After a pair is accepted, `s_ready` stays low until that pair is moved to the active pair.
- R9: Both channels of a frame come from the one pair loaded at the start of its left half. A pair accepted during a frame does not change that frame.
- R10: If no pair is held when a left half starts, that whole frame is sent as zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| master_en | input | 1 | 1: generate bit and frame clocks; 0: follow the external clocks |
| fmt_i2s | input | 1 | 0: justified framing; 1: I2S framing |
| slv_rate | input | 2 | Slave bit clock rate: 0 = 64fs, 1 = 48fs, 2 = 32fs |
| bclk_in | input | 1 | External bit clock (slave) |
| fclk_in | input | 1 | External frame clock (slave) |
| bclk_out | output | 1 | Generated bit clock (master), 0 in slave mode |
| fclk_out | output | 1 | Generated frame clock (master), 0 in slave mode |
| s_valid | input | 1 | Sample pair offered |
| s_ready | output | 1 | Holding register empty |
| s_left | input | SAMPLE_W | Left sample, two's complement |
| s_right | input | SAMPLE_W | Right sample, two's complement |
| sdata | output | 1 | Serial data, MSB first |

## Verification
The properties assume the following about the inputs:
- Once a pair is offered, it stays valid and unchanged until it is accepted.
- In slave mode, the external clocks are synchronous to the system clock.
- Each external bit clock level lasts at least two system clocks.
- The external frame clock changes only together with a falling edge of the bit clock.
- The configuration pins change only while reset is asserted.

The bench keeps to these assumptions. It drives its slave clocks from the falling system clock edge at two system clocks per level. It holds every offered pair until acceptance. It changes mode, format and rate only inside a reset.

// File: rtl/ast_pkg.sv
`timescale 1ns/1ps
package ast_pkg;
  typedef enum logic [1:0] {
    RATE_64 = 2'd0,
    RATE_48 = 2'd1,
    RATE_32 = 2'd2,
    RATE_RSV = 2'd3
  } rate_e;
endpackage

// File: rtl/ast_clk_src.sv
`timescale 1ns/1ps
module ast_clk_src #(
  parameter int CLK_HALF   = 2,
  parameter int HALF_SLOTS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic master_en,
  input  logic bclk_in,
  input  logic fclk_in,
  output logic bclk_int,
  output logic fclk_int,
  output logic bclk_out,
  output logic fclk_out
);
  localparam int DIV_W = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;
  localparam int SL_W  = (HALF_SLOTS > 1) ? $clog2(HALF_SLOTS) : 1;

  logic [DIV_W-1:0] div_q;
  logic [SL_W-1:0]  slot_q;
  logic             bclk_g, fclk_g;
  logic             bclk_s, fclk_s;

  // slave clocks: one register stage into the system clock domain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_s <= 1'b0;
      fclk_s <= 1'b0;
    end else begin
      bclk_s <= bclk_in;
      fclk_s <= fclk_in;
    end
  end

  // master clock generator: frame clock flips with a bit clock fall
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      slot_q <= '0;
      bclk_g <= 1'b0;
      fclk_g <= 1'b0;
    end else if (!master_en) begin
      div_q  <= '0;
      slot_q <= '0;
      bclk_g <= 1'b0;
      fclk_g <= 1'b0;
    end else if (div_q == DIV_W'(CLK_HALF - 1)) begin
      div_q  <= '0;
      bclk_g <= ~bclk_g;
      if (bclk_g) begin
        if (slot_q == SL_W'(HALF_SLOTS - 1)) begin
          slot_q <= '0;
          fclk_g <= ~fclk_g;
        end else begin
          slot_q <= slot_q + 1'b1;
        end
      end
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign bclk_int = master_en ? bclk_g : bclk_s;
  assign fclk_int = master_en ? fclk_g : fclk_s;
  assign bclk_out = bclk_g;
  assign fclk_out = fclk_g;
endmodule

// File: rtl/ast_frame_trk.sv
`timescale 1ns/1ps
module ast_frame_trk #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk,
  input  logic             fclk,
  input  logic             fmt_i2s,
  output logic             fall,
  output logic             half_start,
  output logic             is_left,
  output logic             load,
  output logic [CNT_W-1:0] slot_nx
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             bclk_q;
  logic             fr_last;
  logic [CNT_W-1:0] cnt_q;

  assign fall       = bclk_q & ~bclk;
  assign half_start = fall && (fclk != fr_last);
  assign is_left    = fmt_i2s ? ~fclk : fclk;
  assign load       = half_start & is_left;

  always_comb begin
    if (half_start)          slot_nx = '0;
    else if (cnt_q == CNT_MAX) slot_nx = cnt_q;
    else                     slot_nx = cnt_q + 1'b1;
  end

  // counter starts saturated so nothing is sent before the first frame edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q  <= 1'b0;
      fr_last <= 1'b0;
      cnt_q   <= CNT_MAX;
    end else begin
      bclk_q <= bclk;
      if (fall) begin
        cnt_q <= slot_nx;
        if (half_start) fr_last <= fclk;
      end
    end
  end
endmodule

// File: rtl/ast_pair_buf.sv
`timescale 1ns/1ps
module ast_pair_buf #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  input  logic [W-1:0] s_left,
  input  logic [W-1:0] s_right,
  input  logic         load,
  output logic         s_ready,
  output logic [W-1:0] cur_l,
  output logic [W-1:0] cur_r
);
  logic [W-1:0] hold_l, hold_r, act_l, act_r;
  logic         full;
  logic         accept;

  assign s_ready = ~full;
  assign accept  = s_valid & ~full;

  // a pair loaded this cycle is already visible to the serializer
  always_comb begin
    if (load) begin
      cur_l = full ? hold_l : '0;
      cur_r = full ? hold_r : '0;
    end else begin
      cur_l = act_l;
      cur_r = act_r;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_l <= '0;
      hold_r <= '0;
      act_l  <= '0;
      act_r  <= '0;
      full   <= 1'b0;
    end else begin
      if (accept) begin
        hold_l <= s_left;
        hold_r <= s_right;
      end
      if (load) begin
        act_l <= full ? hold_l : '0;
        act_r <= full ? hold_r : '0;
        full  <= accept;
      end else begin
        full <= full | accept;
      end
    end
  end
endmodule

// File: rtl/ast_shifter.sv
`timescale 1ns/1ps
module ast_shifter
  import ast_pkg::*;
#(
  parameter int W     = 24,
  parameter int TW    = 16,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall,
  input  logic             is_left,
  input  logic             fmt_i2s,
  input  rate_e            rate,
  input  logic [CNT_W-1:0] slot,
  input  logic [W-1:0]     cur_l,
  input  logic [W-1:0]     cur_r,
  output logic             sdata
);
  logic [CNT_W-1:0] width;
  logic [W-1:0]     word, shifted;
  logic             jbit, jbit_q;

  assign width   = (rate == RATE_32) ? CNT_W'(TW) : CNT_W'(W);
  assign word    = is_left ? cur_l : cur_r;
  assign shifted = word << slot;
  assign jbit    = (slot < width) ? shifted[W-1] : 1'b0;

  // I2S stream = justified stream one slot later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      jbit_q <= 1'b0;
      sdata  <= 1'b0;
    end else if (fall) begin
      jbit_q <= jbit;
      sdata  <= fmt_i2s ? jbit_q : jbit;
    end
  end
endmodule

// File: rtl/aud_ser_tx.sv
`timescale 1ns/1ps
module aud_ser_tx
  import ast_pkg::*;
#(
  parameter int SAMPLE_W   = 24,
  parameter int TRUNC_W    = 16,
  parameter int CLK_HALF   = 2,
  parameter int HALF_SLOTS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                master_en,
  input  logic                fmt_i2s,
  input  logic [1:0]          slv_rate,
  input  logic                bclk_in,
  input  logic                fclk_in,
  output logic                bclk_out,
  output logic                fclk_out,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_left,
  input  logic [SAMPLE_W-1:0] s_right,
  output logic                sdata
);
  localparam int CNT_W = $clog2(HALF_SLOTS) + 1;

  logic             bclk_int, fclk_int;
  logic             trk_fall, trk_half, trk_left, trk_load;
  logic [CNT_W-1:0] trk_slot;
  logic [SAMPLE_W-1:0] cur_l, cur_r;
  rate_e            rate_eff;

  assign rate_eff = master_en ? RATE_64 : rate_e'(slv_rate);

  ast_clk_src #(.CLK_HALF(CLK_HALF), .HALF_SLOTS(HALF_SLOTS)) u_clk (
    .clk(clk), .rst_n(rst_n), .master_en(master_en),
    .bclk_in(bclk_in), .fclk_in(fclk_in),
    .bclk_int(bclk_int), .fclk_int(fclk_int),
    .bclk_out(bclk_out), .fclk_out(fclk_out)
  );

  ast_frame_trk #(.CNT_W(CNT_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .bclk(bclk_int), .fclk(fclk_int),
    .fmt_i2s(fmt_i2s), .fall(trk_fall), .half_start(trk_half),
    .is_left(trk_left), .load(trk_load), .slot_nx(trk_slot)
  );

  ast_pair_buf #(.W(SAMPLE_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_left(s_left),
    .s_right(s_right), .load(trk_load), .s_ready(s_ready),
    .cur_l(cur_l), .cur_r(cur_r)
  );

  ast_shifter #(.W(SAMPLE_W), .TW(TRUNC_W), .CNT_W(CNT_W)) u_shf (
    .clk(clk), .rst_n(rst_n), .fall(trk_fall), .is_left(trk_left),
    .fmt_i2s(fmt_i2s), .rate(rate_eff), .slot(trk_slot),
    .cur_l(cur_l), .cur_r(cur_r), .sdata(sdata)
  );

  logic unused_half;
  assign unused_half = trk_half;
endmodule

// File: rtl/aud_ser_tx_chk.sv
`timescale 1ns/1ps
module aud_ser_tx_chk #(
  parameter int SAMPLE_W = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic                master_en,
  input logic                bclk_out,
  input logic                fclk_out,
  input logic                s_valid,
  input logic                s_ready,
  input logic [SAMPLE_W-1:0] s_left,
  input logic [SAMPLE_W-1:0] s_right,
  input logic                sdata,
  input logic                fall,
  input logic                load
);
  a_r3_sdata_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata) |-> $past(fall));

  a_r2_fclk_on_bclk_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (master_en && !$stable(fclk_out)) |-> $fell(bclk_out));

  a_r8_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);

  a_r8_source_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && !s_ready) |=> (s_valid && $stable(s_left) && $stable(s_right)));

  a_r9_ready_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s_ready) |-> $past(load));
endmodule

bind aud_ser_tx aud_ser_tx_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .master_en(master_en),
  .bclk_out(bclk_out), .fclk_out(fclk_out),
  .s_valid(s_valid), .s_ready(s_ready), .s_left(s_left), .s_right(s_right),
  .sdata(sdata), .fall(trk_fall), .load(trk_load)
);

// File: tb/aud_ser_tx_bench.sv
`timescale 1ns/1ps
module aud_ser_tx_bench;
  localparam int CLK_P   = 8;
  localparam int NPAIRS  = 4;
  localparam int NFRAMES = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_en = 1'b0, fmt_i2s = 1'b0;
  logic [1:0] slv_rate = 2'd0;
  logic bclk_in = 1'b0, fclk_in = 1'b0;
  logic bclk_out, fclk_out, s_ready, sdata;
  logic s_valid = 1'b0;
  logic [23:0] s_left = '0, s_right = '0;

  int n_chk = 0, n_fail = 0;

  aud_ser_tx u_aud_ser_tx (
    .clk(clk), .rst_n(rst_n), .master_en(master_en), .fmt_i2s(fmt_i2s),
    .slv_rate(slv_rate), .bclk_in(bclk_in), .fclk_in(fclk_in),
    .bclk_out(bclk_out), .fclk_out(fclk_out), .s_valid(s_valid),
    .s_ready(s_ready), .s_left(s_left), .s_right(s_right), .sdata(sdata)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] pat(int k, bit rt);
    logic [31:0] t;
    if (k < 0 || k >= NPAIRS) return 24'h0;
    if (k == 0) return rt ? 24'h7FFFFF : 24'h800000;
    if (k == 1) return rt ? 24'h000001 : 24'hFFFFFF;
    t = (32'(k) * 32'h0009_3A5F) ^ 32'h00A5_5A3C;
    return rt ? (~t[23:0] ^ 24'(k << 4)) : t[23:0];
  endfunction

  // slave clock stimulus: two system clocks per level
  bit sl_run = 0;
  int sl_slots = 32;
  initial begin
    int dv = 0, sc = 0;
    forever begin
      @(negedge clk);
      if (!sl_run) begin
        dv = 0; sc = 0;
      end else if (dv == 1) begin
        dv = 0;
        if (bclk_in) begin
          if (sc == sl_slots - 1) begin
            sc = 0; fclk_in = ~fclk_in;
          end else sc++;
        end
        bclk_in = ~bclk_in;
      end else dv++;
    end
  end

  // receiver: samples a quarter period after the rising system clock edge
  bit cfg_m = 0, cfg_f = 0;
  int cfg_r = 0, exp_slots = 32, exp_w = 24;
  bit rx_on = 0, rx_started = 0, rx_b_prev = 0, rx_last_f = 0, rx_bad = 0, rx_per_bad = 0;
  int rx_slot = 0, rx_k = -1, rx_per = 0;
  logic [23:0] cur_word = '0, prev_word = '0;
  logic rx_act = 0, rx_exp = 0;

  task automatic finish_half();
    string tg;
    tg = (rx_k >= NPAIRS) ? "R10" :
         (cfg_m ? "R2 R9" : (cfg_r == 2 ? "R7 R9" : (cfg_r == 1 ? "R6 R9" : "R9")));
    // R3: every bit was taken at a rising edge of the bit clock
    check(!rx_bad && !rx_per_bad && (rx_slot + 1 == exp_slots),
          $sformatf("%s %s half k=%0d slots=%0d", cfg_f ? "R5" : "R4", tg, rx_k, rx_slot + 1),
          {30'd0, rx_act, rx_exp}, {30'd0, rx_exp, rx_exp});
  endtask

  initial begin
    bit b, f, lf, e;
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (rx_on) begin
        b = cfg_m ? bclk_out : bclk_in;
        f = cfg_m ? fclk_out : fclk_in;
        rx_per++;
        if (b && !rx_b_prev) begin
          if (cfg_m && rx_started && rx_per != 4) rx_per_bad = 1;  // R2 period
          rx_per = 0;
          if (f != rx_last_f) begin
            if (rx_started) finish_half();
            rx_started = 1; rx_last_f = f; rx_slot = 0; rx_bad = 0; rx_per_bad = 0;
            lf = cfg_f ? !f : f;
            if (lf) rx_k++;
            prev_word = cur_word;
            cur_word = pat(rx_k, !lf);
          end else rx_slot++;
          if (rx_started) begin
            if (!cfg_f) e = (rx_slot < exp_w) ? cur_word[23 - rx_slot] : 1'b0;
            else if (rx_slot == 0) e = (exp_slots == exp_w) ? prev_word[24 - exp_w] : 1'b0;
            else e = (rx_slot - 1 < exp_w) ? cur_word[24 - rx_slot] : 1'b0;
            if (sdata !== e && !rx_bad) begin
              rx_bad = 1; rx_act = sdata; rx_exp = e;
            end
          end
        end
        rx_b_prev = b;
      end
    end
  end

  task automatic push(int k);
    @(negedge clk);
    s_valid = 1'b1; s_left = pat(k, 0); s_right = pat(k, 1);
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic run_cfg(bit m, bit f, int r);
    @(negedge clk);
    rst_n = 0; s_valid = 0; sl_run = 0;
    cfg_m = m; cfg_f = f; cfg_r = r;
    master_en = m; fmt_i2s = f; slv_rate = 2'(r);
    bclk_in = 0; fclk_in = f;
    sl_slots  = (r == 2) ? 16 : (r == 1) ? 24 : 32;
    exp_slots = m ? 32 : sl_slots;
    exp_w     = (!m && r == 2) ? 16 : 24;
    repeat (3) @(negedge clk);
    check({sdata, s_ready, bclk_out, fclk_out} == 4'b0100, "R1 reset state",
          {28'd0, sdata, s_ready, bclk_out, fclk_out}, 32'h4);
    rx_last_f = m ? 1'b0 : f; rx_started = 0; rx_b_prev = 0; rx_k = -1;
    cur_word = '0; prev_word = '0; rx_per = 0; rx_on = 1;
    rst_n = 1;
    push(0);
    repeat (4) @(negedge clk);
    check(s_ready == 1'b0, "R8 ready low while pair held", {31'd0, s_ready}, 32'h0);
    if (!m) sl_run = 1;
    for (int k = 1; k < NPAIRS; k++) push(k);
    wait (rx_k >= NFRAMES);
    rx_on = 0; sl_run = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    for (int f = 0; f < 2; f++) begin
      run_cfg(1'b1, f[0], 2);   // R2: slv_rate ignored in master mode
      for (int r = 0; r < 3; r++) run_cfg(1'b0, f[0], r);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule